// File: doc/BRIEF.md
# Processor Status Register Unit

This unit keeps the live 32-bit processor status word and a single saved copy of it. Three kinds of event change the live word. A move-to-status operation writes either register through four byte-lane enables. The ALU can overwrite the four condition flags. An accepted interrupt switches the mode, raises the interrupt masks and forces the 32-bit instruction state, after the old word has been copied into the saved register. The unit also reports which interrupt it accepts, so that the fetch logic upstream can redirect.

A small sequencer controls interrupt entry. In state `ST_RUN` the unit accepts writes and flag updates and checks the two request lines. When it accepts a fast request it moves to `ST_ENTER_FIQ`. When it accepts a normal request it moves to `ST_ENTER_IRQ`. Each entry state lasts one cycle. At its closing edge the unit applies the entry update and returns to `ST_RUN`. These three transitions are the only ones the sequencer has.

Layout of the status word:

| Bits | Content |
|---|---|
| [31:28] | Flags N, Z, C, V (bit 31 is N, bit 28 is V) |
| 7 | I, masks the normal interrupt |
| 6 | F, masks the fast interrupt |
| 5 | T |
| [4:0] | Mode |

Mode codes: user 10000, fast interrupt 10001, normal interrupt 10010, supervisor 10011.

Top module: `psr_unit`

## Requirements
- R1: While reset is held and afterwards, until the first write, the live word reads 0x000000D3 (supervisor mode, I=1, F=1, T=0, flags clear) and the saved word reads 0. Neither take output is high.
- R2: In a non-user mode, a write in ST_RUN with the saved-select low updates byte lane k of the live word if and only if mask bit k is set. Mask bit 3 covers [31:24], bit 2 covers [23:16], bit 1 covers [15:8] and bit 0 covers [7:0]. The new value is visible after the next clock edge.
- R3: A write with the saved-select high applies the same lane masking to the saved word and leaves the live word unchanged.
- R4: A flag-update strobe in ST_RUN loads bits [31:28] with the input in the order N, Z, C, V from the top down. If a write to the flag lane occurs in the same cycle, the strobe wins on those four bits.
- R5: The mode output always equals bits [4:0] of the live word. The instruction-state output always equals bit 5 (0 selects the 32-bit state, 1 selects the 16-bit state).
- R6: In ST_RUN, the normal take output is high exactly when the active-low normal request is low, I is 0 and no fast take is present. The fast take output is high exactly when the active-low fast request is low and F is 0. Both take outputs are low in the entry states.
- R7: When both requests are accepted in the same cycle, only the fast take is raised.
- R8: After a normal take, the sequencer spends one cycle in ST_ENTER_IRQ. At the end of that cycle the saved word receives the live word, the mode becomes 10010, I becomes 1 and T becomes 0. F and bits [31:8] are unchanged.
- R9: After a fast take, the sequencer spends one cycle in ST_ENTER_FIQ. At the end of that cycle the saved word receives the live word, the mode becomes 10001, I and F both become 1 and T becomes 0.
- R10: During either entry cycle, writes and flag strobes have no effect on either register.
- R11: In user mode (10000), a write to the live word changes only the flag lane [31:24]. A write to the saved word is ignored entirely. The flag-update strobe still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| psr_wr_en | input | 1 | Move-to-status write strobe |
| psr_wr_saved | input | 1 | 1 targets the saved word, 0 targets the live word |
| psr_wr_mask | input | 4 | Byte-lane enables, bit k covers bits [8k+7:8k] |
| psr_wr_data | input | 32 | Write data |
| flag_upd | input | 1 | Flag-update strobe from the ALU |
| flag_nzcv | input | 4 | New flags, N in bit 3 down to V in bit 0 |
| irq_req_n | input | 1 | Normal interrupt request, active low |
| fiq_req_n | input | 1 | Fast interrupt request, active low |
| cur_psr | output | 32 | Live status word |
| saved_psr | output | 32 | Saved status word |
| cur_mode | output | 5 | Current mode field |
| thumb_state | output | 1 | Instruction-state bit T |
| irq_take | output | 1 | Normal interrupt accepted this cycle |
| fiq_take | output | 1 | Fast interrupt accepted this cycle |

## Verification
The bench drives the unit with these directed patterns:
- Single-lane, two-lane, empty and full write masks. These separate a lane-decoding fault from a stuck enable.
- A flag strobe alone, and a flag strobe in the same cycle as a flag-lane write. These show which source wins on [31:28].
- Requests raised while masked, while unmasked, and both at once. These separate the masking terms from the priority term.
- Writes held high through the entry cycles, and user-mode writes to every lane. These expose any leak past the entry lockout or the user-mode lane guard.

A long stretch of random writes, strobes and request patterns then follows. A cycle-level behavioural model compares every output on every clock, so faults that show up only in rare combinations are also caught.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned LANE_W    = 8;
    localparam int unsigned LANES     = WORD_W / LANE_W;
    localparam int unsigned MODE_W    = 5;
    localparam int unsigned FLAG_W    = 4;

    localparam int unsigned BIT_I     = 7;
    localparam int unsigned BIT_F     = 6;
    localparam int unsigned BIT_T     = 5;
    localparam int unsigned FLAG_LSB  = WORD_W - FLAG_W;

    localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;

    localparam logic [WORD_W-1:0] LIVE_RESET  = 32'h0000_00D3;
    localparam logic [WORD_W-1:0] SAVED_RESET = '0;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_ENTER_IRQ = 2'd1,
        ST_ENTER_FIQ = 2'd2
    } entry_state_e;

    function automatic logic [WORD_W-1:0] enter_word(
        input logic [WORD_W-1:0] old,
        input logic              fast
    );
        logic [WORD_W-1:0] w;
        w = old;
        w[BIT_I] = 1'b1;
        if (fast) begin
            w[BIT_F] = 1'b1;
        end
        w[BIT_T] = 1'b0;
        w[MODE_W-1:0] = fast ? MODE_FIQ : MODE_IRQ;
        return w;
    endfunction

endpackage

// File: rtl/psr_lane_merge.sv
module psr_lane_merge #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned W     = LANES * LANE_W
) (
    input  logic [W-1:0]     old_word,
    input  logic [W-1:0]     new_word,
    input  logic [LANES-1:0] lane_en,
    output logic [W-1:0]     merged
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign merged[k*LANE_W +: LANE_W] = lane_en[k] ? new_word[k*LANE_W +: LANE_W]
                                                       : old_word[k*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/psr_int_arbiter.sv
module psr_int_arbiter (
    input  logic arb_en,
    input  logic irq_req_n,
    input  logic fiq_req_n,
    input  logic mask_i,
    input  logic mask_f,
    output logic irq_take,
    output logic fiq_take
);

    logic fiq_ok;
    logic irq_ok;

    always_comb begin
        fiq_ok   = ~fiq_req_n & ~mask_f;
        irq_ok   = ~irq_req_n & ~mask_i;
        fiq_take = arb_en & fiq_ok;
        irq_take = arb_en & irq_ok & ~fiq_ok;
    end

endmodule

// File: rtl/psr_entry_fsm.sv
module psr_entry_fsm
    import psr_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         irq_take,
    input  logic         fiq_take,
    output entry_state_e state,
    output logic         in_run,
    output logic         entry_fast
);

    entry_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (fiq_take) begin
                    state_nx = ST_ENTER_FIQ;
                end else if (irq_take) begin
                    state_nx = ST_ENTER_IRQ;
                end
            end
            ST_ENTER_IRQ: state_nx = ST_RUN;
            ST_ENTER_FIQ: state_nx = ST_RUN;
            default:      state_nx = ST_RUN;
        endcase
    end

    always_comb begin
        in_run     = 1'b0;
        entry_fast = 1'b0;
        unique case (state)
            ST_RUN:       in_run = 1'b1;
            ST_ENTER_IRQ: entry_fast = 1'b0;
            ST_ENTER_FIQ: entry_fast = 1'b1;
            default:      in_run = 1'b1;
        endcase
    end

endmodule

// File: rtl/psr_unit.sv
module psr_unit
    import psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psr_wr_en,
    input  logic              psr_wr_saved,
    input  logic [LANES-1:0]  psr_wr_mask,
    input  logic [WORD_W-1:0] psr_wr_data,
    input  logic              flag_upd,
    input  logic [FLAG_W-1:0] flag_nzcv,
    input  logic              irq_req_n,
    input  logic              fiq_req_n,
    output logic [WORD_W-1:0] cur_psr,
    output logic [WORD_W-1:0] saved_psr,
    output logic [MODE_W-1:0] cur_mode,
    output logic              thumb_state,
    output logic              irq_take,
    output logic              fiq_take
);

    logic [WORD_W-1:0] live_q;
    logic [WORD_W-1:0] saved_q;
    logic [WORD_W-1:0] live_merged;
    logic [WORD_W-1:0] saved_merged;
    logic [WORD_W-1:0] live_next;
    logic [LANES-1:0]  live_lane_en;
    logic [LANES-1:0]  saved_lane_en;
    logic              user_mode;
    logic              in_run;
    logic              entry_fast;
    entry_state_e      state;

    assign user_mode = (live_q[MODE_W-1:0] == MODE_USR);

    // lane enables; in user mode only the top lane of the live word is open
    for (genvar k = 0; k < LANES; k++) begin : g_en
        if (k == LANES - 1) begin : g_flag_lane
            assign live_lane_en[k] = in_run & psr_wr_en & ~psr_wr_saved & psr_wr_mask[k];
        end else begin : g_low_lane
            assign live_lane_en[k] = in_run & psr_wr_en & ~psr_wr_saved & psr_wr_mask[k]
                                     & ~user_mode;
        end
        assign saved_lane_en[k] = in_run & psr_wr_en & psr_wr_saved & psr_wr_mask[k]
                                  & ~user_mode;
    end

    psr_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_live_merge (
        .old_word (live_q),
        .new_word (psr_wr_data),
        .lane_en  (live_lane_en),
        .merged   (live_merged)
    );

    psr_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_saved_merge (
        .old_word (saved_q),
        .new_word (psr_wr_data),
        .lane_en  (saved_lane_en),
        .merged   (saved_merged)
    );

    always_comb begin
        live_next = live_merged;
        if (flag_upd) begin
            live_next[WORD_W-1:FLAG_LSB] = flag_nzcv;
        end
    end

    psr_int_arbiter u_arb (
        .arb_en    (in_run),
        .irq_req_n (irq_req_n),
        .fiq_req_n (fiq_req_n),
        .mask_i    (live_q[BIT_I]),
        .mask_f    (live_q[BIT_F]),
        .irq_take  (irq_take),
        .fiq_take  (fiq_take)
    );

    psr_entry_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_take   (irq_take),
        .fiq_take   (fiq_take),
        .state      (state),
        .in_run     (in_run),
        .entry_fast (entry_fast)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q  <= LIVE_RESET;
            saved_q <= SAVED_RESET;
        end else begin
            unique case (state)
                ST_RUN: begin
                    live_q  <= live_next;
                    saved_q <= saved_merged;
                end
                ST_ENTER_IRQ, ST_ENTER_FIQ: begin
                    saved_q <= live_q;
                    live_q  <= enter_word(live_q, entry_fast);
                end
                default: begin
                    live_q  <= live_q;
                    saved_q <= saved_q;
                end
            endcase
        end
    end

    assign cur_psr     = live_q;
    assign saved_psr   = saved_q;
    assign cur_mode    = live_q[MODE_W-1:0];
    assign thumb_state = live_q[BIT_T];

    // R7: never both takes
    a_r7_single_take: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_take && fiq_take));

    // R6: masked fast request is never accepted
    a_r6_fiq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        cur_psr[BIT_F] |-> !fiq_take);

    // R8: normal entry result
    a_r8_irq_entry: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> ##1 (cur_mode == MODE_IRQ && cur_psr[BIT_I] && !thumb_state));

    // R9: fast entry copies the word seen during the entry cycle
    a_r9_saved_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |=> (saved_psr == $past(cur_psr)));

    // R10: entry cycle leaves upper bits untouched
    a_r10_entry_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |=> (cur_psr[WORD_W-1:LANE_W] == $past(cur_psr[WORD_W-1:LANE_W])));

    // R4: strobe lands on the flags
    a_r4_flag_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_upd && state == ST_RUN) |=> (cur_psr[WORD_W-1:FLAG_LSB] == $past(flag_nzcv)));

    // R11: user mode keeps the low three lanes in ST_RUN
    a_r11_user_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_USR && state == ST_RUN) |=>
            (cur_psr[WORD_W-LANE_W-1:0] == $past(cur_psr[WORD_W-LANE_W-1:0])));

endmodule

// File: tb/psr_unit_tb.sv
module psr_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psr_wr_en = 1'b0;
    logic        psr_wr_saved = 1'b0;
    logic [3:0]  psr_wr_mask = '0;
    logic [31:0] psr_wr_data = '0;
    logic        flag_upd = 1'b0;
    logic [3:0]  flag_nzcv = '0;
    logic        irq_req_n = 1'b1;
    logic        fiq_req_n = 1'b1;
    logic [31:0] cur_psr;
    logic [31:0] saved_psr;
    logic [4:0]  cur_mode;
    logic        thumb_state;
    logic        irq_take;
    logic        fiq_take;

    int    vectors = 0;
    int    errors = 0;
    string phase = "R1";
    bit    done = 0;

    // reference model state: 0 run, 1 normal entry, 2 fast entry
    logic [31:0] m_live;
    logic [31:0] m_saved;
    int          m_st;

    always #2.5 clk = ~clk;

    psr_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .psr_wr_en(psr_wr_en), .psr_wr_saved(psr_wr_saved),
        .psr_wr_mask(psr_wr_mask), .psr_wr_data(psr_wr_data),
        .flag_upd(flag_upd), .flag_nzcv(flag_nzcv),
        .irq_req_n(irq_req_n), .fiq_req_n(fiq_req_n),
        .cur_psr(cur_psr), .saved_psr(saved_psr), .cur_mode(cur_mode),
        .thumb_state(thumb_state), .irq_take(irq_take), .fiq_take(fiq_take)
    );

    function automatic bit m_fiq();
        return (m_st == 0) && !fiq_req_n && !m_live[6];
    endfunction

    function automatic bit m_irq();
        return (m_st == 0) && !irq_req_n && !m_live[7] && !m_fiq();
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_live  = 32'h0000_00D3;
            m_saved = 32'h0;
            m_st    = 0;
        end else if (m_st != 0) begin
            m_saved = m_live;
            m_live[7] = 1'b1;
            if (m_st == 2) m_live[6] = 1'b1;
            m_live[5] = 1'b0;
            m_live[4:0] = (m_st == 2) ? 5'b10001 : 5'b10010;
            m_st = 0;
        end else begin
            bit user;
            int nst;
            user = (m_live[4:0] == 5'b10000);
            nst = m_fiq() ? 2 : (m_irq() ? 1 : 0);
            if (psr_wr_en) begin
                for (int k = 0; k < 4; k++) begin
                    if (psr_wr_mask[k]) begin
                        if (psr_wr_saved) begin
                            if (!user) m_saved[k*8 +: 8] = psr_wr_data[k*8 +: 8];
                        end else if (k == 3 || !user) begin
                            m_live[k*8 +: 8] = psr_wr_data[k*8 +: 8];
                        end
                    end
                end
            end
            if (flag_upd) m_live[31:28] = flag_nzcv;
            m_st = nst;
        end
    end

    task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cmp("live word", cur_psr, m_live);
        cmp("saved word", saved_psr, m_saved);
        cmp("mode R5", {27'd0, cur_mode}, {27'd0, m_live[4:0]});
        cmp("state bit R5", {31'd0, thumb_state}, {31'd0, m_live[5]});
        cmp("normal take R6", {31'd0, irq_take}, {31'd0, m_irq()});
        cmp("fast take R7", {31'd0, fiq_take}, {31'd0, m_fiq()});
    endtask

    task automatic wr(input bit sv, input logic [3:0] m, input logic [31:0] d);
        psr_wr_en = 1'b1; psr_wr_saved = sv; psr_wr_mask = m; psr_wr_data = d;
        tick();
        psr_wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        phase = "R1";
        repeat (3) tick();
        rst_n = 1'b1;
        tick(); tick();

        phase = "R2";
        wr(0, 4'b0110, 32'hAABBCCD3);
        wr(0, 4'b1001, 32'h5F0000D3);
        wr(0, 4'b0000, 32'hFFFFFFFF);
        wr(0, 4'b0100, 32'h00770000);
        wr(0, 4'b1111, 32'h000000D3);
        wr(0, 4'b1000, 32'hA0000000);
        tick();

        phase = "R4";
        flag_upd = 1'b1; flag_nzcv = 4'b0101; tick();
        flag_nzcv = 4'b0011;
        wr(0, 4'b1000, 32'hF0000000);
        flag_upd = 1'b0; tick();

        phase = "R3";
        wr(1, 4'b1111, 32'h11223344);
        wr(1, 4'b0100, 32'hFFFFFFFF);
        wr(1, 4'b0001, 32'h000000EE);

        phase = "R5";
        wr(0, 4'b0001, 32'h000000F3);
        wr(0, 4'b0001, 32'h000000D3);

        phase = "R6";
        irq_req_n = 1'b0; tick(); tick();
        wr(0, 4'b0001, 32'h00000053);

        phase = "R8";
        repeat (3) tick();
        irq_req_n = 1'b1; tick();

        phase = "R7";
        wr(0, 4'b0001, 32'h00000013);
        irq_req_n = 1'b0; fiq_req_n = 1'b0;
        tick();

        phase = "R10";
        psr_wr_en = 1'b1; psr_wr_saved = 1'b0; psr_wr_mask = 4'hF; psr_wr_data = 32'h0;
        flag_upd = 1'b1; flag_nzcv = 4'hF;
        tick();
        psr_wr_en = 1'b0; flag_upd = 1'b0;

        phase = "R9";
        tick(); tick();
        irq_req_n = 1'b1; fiq_req_n = 1'b1; tick();

        phase = "R11";
        wr(0, 4'b0001, 32'h000000D0);
        wr(0, 4'b1111, 32'h6FFFFF1F);
        wr(1, 4'b1111, 32'h12345678);
        flag_upd = 1'b1; flag_nzcv = 4'b1001; tick(); flag_upd = 1'b0;
        wr(0, 4'b1000, 32'hC0000000);
        wr(0, 4'b0001, 32'h00000010);
        fiq_req_n = 1'b0; tick(); tick(); tick();
        fiq_req_n = 1'b1; tick();

        phase = "mixed R2 R3 R4 R6 R7 R8 R9 R10 R11";
        for (int n = 0; n < 4000; n++) begin
            psr_wr_en    = ($urandom % 3) == 0;
            psr_wr_saved = $urandom % 2;
            psr_wr_mask  = 4'($urandom);
            psr_wr_data  = $urandom;
            if (($urandom % 4) == 0) psr_wr_data[4:0] = 5'b10000;
            flag_upd     = $urandom % 2;
            flag_nzcv    = 4'($urandom);
            irq_req_n    = ($urandom % 4) != 0;
            fiq_req_n    = ($urandom % 6) != 0;
            tick();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule